// File: doc/BRIEF.md
# Slice-Pipelined Trilinear Interpolator

This block turns a raster stream of 8-bit voxels into trilinearly interpolated samples at a rate of one per clock. Voxels arrive one per accepted cycle with X varying fastest, then Y, then Z, so a slice holds `NX*NY` voxels. The sample that belongs to an accepted voxel is built from the cube of eight voxels whose newest corner is that voxel. Four of the corners come from the current slice. The other four come from an internal slice delay line, so the voxel store upstream is read only once.

Each accepted voxel comes with three 8-bit resampling weights (X, Y, Z) and an opaque control word. Seven single-multiplier linear interpolators form a three-level tree: four work along X, two along Y and one along Z, with a register after each level. The control word travels through the same registers, so it leaves together with its sample. A start-of-volume flag restarts the fill phase, and a valid strobe marks the samples whose neighbourhood is complete.

Top module: `trilinear_sampler`

## Requirements
- R1: While reset is asserted, and for the first three cycles after it is released, `out_valid` is low.
- R2: Each interpolator returns the upper 8 bits of the 16-bit value `(hi-lo)*w + lo*256`, truncated. This equals `lo + floor((hi-lo)*w/256)`. With `w=0` it returns `lo` exactly, and the result never leaves the range spanned by `hi` and `lo`.
- R3: Number the accepted voxels k = 0, 1, … from reset or from the last start-of-volume. The sample for voxel k uses the voxels at k, k-1, k-NX and k-NX-1, and the same four positions shifted back by S = NX*NY.
- R4: The tree applies `in_wx` first, pairing k with k-1 in each row. It then applies `in_wy`, pairing row k with row k-NX. It applies `in_wz` last, pairing the current slice (`hi`) with the previous slice (`lo`). In every pair, `hi` is the newer voxel.
- R5: A sample appears on the outputs exactly three clock cycles after its voxel is accepted. An unbroken input stream gives one valid sample on every cycle.
- R6: Voxels with index k ≤ S+NX produce no valid sample. Every accepted voxel with k ≥ S+NX+1 produces one.
- R7: Asserting `in_sov` together with `in_valid` makes that voxel index 0, even in the middle of a stream. Filling then starts again from that voxel.
- R8: A cycle with `in_valid` low neither advances the delay lines nor produces a sample. The stream goes on as if the idle cycle had not happened.
- R9: `out_ctrl` carries the control word and `out_sample` uses the weights that were presented with the same accepted voxel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A voxel is presented this cycle |
| in_sov | input | 1 | This voxel is index 0 of a new volume |
| in_voxel | input | 8 | Voxel value |
| in_wx | input | 8 | X resampling weight, position w/256 |
| in_wy | input | 8 | Y resampling weight |
| in_wz | input | 8 | Z resampling weight |
| in_ctrl | input | CTRL_W | Control word passed through with the sample |
| out_valid | output | 1 | `out_sample` and `out_ctrl` are valid |
| out_sample | output | 8 | Interpolated sample |
| out_ctrl | output | CTRL_W | Control word aligned with the sample |

## Verification
The bench targets the edge of the fill window, at index S+NX versus S+NX+1. A design that is off by one there either emits a sample built from a stale or garbage corner, or loses the first good sample. Weights of zero must return the oldest corner exactly, and weights of 255 must stay just below the newest corner. A design with the pairs or the weight order swapped returns the wrong corner or a different truncation. Random idle cycles and a start-of-volume in the middle of a stream are also driven. A delay line that shifts while idle would misalign every later sample, and a fill counter that ignores the restart would mark samples valid while their corners still come from the old volume.

// File: rtl/trilerp_pkg.sv
package trilerp_pkg;
    localparam int VOX_W = 8;   // voxel and sample width
    localparam int WGT_W = 8;   // resampling weight width, weight = w / 2**WGT_W

    typedef logic [VOX_W-1:0] voxel_t;
    typedef logic [WGT_W-1:0] weight_t;
endpackage

// File: rtl/trilerp_lerp.sv
// One linear interpolator with a single multiplier: lo + (hi - lo) * w / 2**WGT_W.
module trilerp_lerp
    import trilerp_pkg::*;
(
    input  voxel_t  hi,
    input  voxel_t  lo,
    input  weight_t w,
    output voxel_t  y
);
    localparam int ACC_W = VOX_W + WGT_W + 3;

    logic signed [ACC_W-1:0] diff;
    logic signed [ACC_W-1:0] wgt;
    logic signed [ACC_W-1:0] base;
    logic signed [ACC_W-1:0] acc;

    always_comb begin
        diff = $signed({{(ACC_W-VOX_W){1'b0}}, hi}) - $signed({{(ACC_W-VOX_W){1'b0}}, lo});
        wgt  = $signed({{(ACC_W-WGT_W){1'b0}}, w});
        base = $signed({{(ACC_W-VOX_W-WGT_W){1'b0}}, lo, {WGT_W{1'b0}}});
        acc  = diff * wgt + base;
        y    = acc[VOX_W+WGT_W-1 -: VOX_W];
    end

    // R2: the truncated result stays between the two neighbours
    always_comb begin
        p_lerp_bounds_r2: assert ((acc >= 0) &&
                                  ((hi >= lo) ? (y >= lo && y <= hi) : (y >= hi && y <= lo)));
    end
endmodule

// File: rtl/trilerp_slice_fifo.sv
// Slice delay line: returns the value written DEPTH accepted cycles earlier.
module trilerp_slice_fifo
    import trilerp_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  voxel_t din,
    output voxel_t dout
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    voxel_t   mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.ptr = (int'(st_q.ptr) == DEPTH - 1) ? '0 : st_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read-before-write at the same slot gives exactly DEPTH cycles of delay
    always_ff @(posedge clk) begin
        if (en) mem[st_q.ptr] <= din;
    end

    assign dout = mem[st_q.ptr];

    // R3: the ring pointer never leaves the slice length
    p_ptr_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.ptr) < DEPTH);

    // R8: an idle cycle leaves the slice ring where it was
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.ptr));
endmodule

// File: rtl/trilerp_beam_window.sv
// Short shift line giving the X, Y and XY neighbours of the incoming voxel.
module trilerp_beam_window
    import trilerp_pkg::*;
#(
    parameter int NX = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  voxel_t din,
    output voxel_t tap_x,
    output voxel_t tap_y,
    output voxel_t tap_xy
);
    typedef struct packed {
        logic [NX:0][VOX_W-1:0] sh;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.sh = {st_q.sh[NX-1:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tap_x  = st_q.sh[0];
    assign tap_y  = st_q.sh[NX-1];
    assign tap_xy = st_q.sh[NX];

    // R8: the neighbourhood window holds still while no voxel is accepted
    p_window_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.sh));
endmodule

// File: rtl/trilinear_sampler.sv
module trilinear_sampler
    import trilerp_pkg::*;
#(
    parameter int NX     = 8,
    parameter int NY     = 8,
    parameter int CTRL_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sov,
    input  logic [VOX_W-1:0]  in_voxel,
    input  logic [WGT_W-1:0]  in_wx,
    input  logic [WGT_W-1:0]  in_wy,
    input  logic [WGT_W-1:0]  in_wz,
    input  logic [CTRL_W-1:0] in_ctrl,
    output logic              out_valid,
    output logic [VOX_W-1:0]  out_sample,
    output logic [CTRL_W-1:0] out_ctrl
);
    localparam int SLICE  = NX * NY;
    localparam int FILL   = SLICE + NX + 1;      // first index with a full cube
    localparam int FILL_W = $clog2(FILL + 1);
    localparam int N_X    = 4;                   // interpolators per level
    localparam int N_Y    = N_X / 2;

    typedef struct packed {
        logic [FILL_W-1:0]          fill;
        logic                       s1_valid;
        logic [N_X-1:0][VOX_W-1:0]  s1_x;
        weight_t                    s1_wy;
        weight_t                    s1_wz;
        logic [CTRL_W-1:0]          s1_ctrl;
        logic                       s2_valid;
        logic [N_Y-1:0][VOX_W-1:0]  s2_y;
        weight_t                    s2_wz;
        logic [CTRL_W-1:0]          s2_ctrl;
        logic                       s3_valid;
        voxel_t                     s3_sample;
        logic [CTRL_W-1:0]          s3_ctrl;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    // ---------------- neighbourhood alignment ----------------
    voxel_t cur_x, cur_y, cur_xy;
    voxel_t prev_vox, prv_x, prv_y, prv_xy;

    trilerp_beam_window #(.NX(NX)) u_win_cur (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .din(in_voxel),
        .tap_x(cur_x), .tap_y(cur_y), .tap_xy(cur_xy)
    );

    trilerp_slice_fifo #(.DEPTH(SLICE)) u_slice (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .din(in_voxel), .dout(prev_vox)
    );

    trilerp_beam_window #(.NX(NX)) u_win_prev (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .din(prev_vox),
        .tap_x(prv_x), .tap_y(prv_y), .tap_xy(prv_xy)
    );

    // corner index {z,y,x}: a set bit marks the newer neighbour on that axis
    logic [2*N_X-1:0][VOX_W-1:0] corner;
    assign corner = {in_voxel, cur_x, cur_y, cur_xy, prev_vox, prv_x, prv_y, prv_xy};

    // ---------------- interpolation tree ----------------
    logic [N_X-1:0][VOX_W-1:0] x_res;
    logic [N_Y-1:0][VOX_W-1:0] y_res;
    voxel_t                    z_res;

    for (genvar g = 0; g < N_X; g++) begin : g_lerp_x
        trilerp_lerp u_lerp (
            .hi(corner[2*g+1]), .lo(corner[2*g]), .w(in_wx), .y(x_res[g])
        );
    end

    for (genvar g = 0; g < N_Y; g++) begin : g_lerp_y
        trilerp_lerp u_lerp (
            .hi(st_q.s1_x[2*g+1]), .lo(st_q.s1_x[2*g]), .w(st_q.s1_wy), .y(y_res[g])
        );
    end

    trilerp_lerp u_lerp_z (
        .hi(st_q.s2_y[1]), .lo(st_q.s2_y[0]), .w(st_q.s2_wz), .y(z_res)
    );

    // ---------------- next state ----------------
    logic [FILL_W-1:0] idx;

    always_comb begin
        st_d = st_q;
        idx  = in_sov ? '0 : st_q.fill;
        if (in_valid) begin
            st_d.fill = (idx == FILL_W'(FILL)) ? idx : idx + FILL_W'(1);
        end

        st_d.s1_valid  = in_valid && (idx == FILL_W'(FILL));
        st_d.s1_x      = x_res;
        st_d.s1_wy     = in_wy;
        st_d.s1_wz     = in_wz;
        st_d.s1_ctrl   = in_ctrl;

        st_d.s2_valid  = st_q.s1_valid;
        st_d.s2_y      = y_res;
        st_d.s2_wz     = st_q.s1_wz;
        st_d.s2_ctrl   = st_q.s1_ctrl;

        st_d.s3_valid  = st_q.s2_valid;
        st_d.s3_sample = z_res;
        st_d.s3_ctrl   = st_q.s2_ctrl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.s3_valid;
    assign out_sample = st_q.s3_sample;
    assign out_ctrl   = st_q.s3_ctrl;

    // ---------------- assertions ----------------
    // R6 and R7: a start-of-volume voxel never yields a sample
    p_sov_starts_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sov) |=> !st_q.s1_valid);

    // R8: no accepted voxel, no sample entering the tree
    p_idle_no_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !st_q.s1_valid);

    // R5: every valid output traces back to a voxel accepted three cycles earlier
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));
endmodule

// File: tb/trilinear_sampler_bench.sv
module trilinear_sampler_bench;
    localparam int NX     = 8;
    localparam int NY     = 8;
    localparam int CTRL_W = 13;
    localparam int SLICE  = NX * NY;
    localparam int FILL   = SLICE + NX + 1;
    localparam int HIST   = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sov = 1'b0;
    logic [7:0]        in_voxel = '0;
    logic [7:0]        in_wx = '0;
    logic [7:0]        in_wy = '0;
    logic [7:0]        in_wz = '0;
    logic [CTRL_W-1:0] in_ctrl = '0;
    logic              out_valid;
    logic [7:0]        out_sample;
    logic [CTRL_W-1:0] out_ctrl;

    always #4 clk = ~clk;   // 125 MHz

    trilinear_sampler #(.NX(NX), .NY(NY), .CTRL_W(CTRL_W)) u_trilinear_sampler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sov(in_sov),
        .in_voxel(in_voxel), .in_wx(in_wx), .in_wy(in_wy), .in_wz(in_wz),
        .in_ctrl(in_ctrl), .out_valid(out_valid), .out_sample(out_sample),
        .out_ctrl(out_ctrl)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    int    hist [HIST];
    int    cnt_m = 0;
    int    t = 0;
    bit    ev [4];
    int    es [4];
    int    ec [4];
    string et [4];

    function automatic int lerp_ref(int hi, int lo, int w);
        int s;
        s = lo * 256 + (hi - lo) * w;
        return (s >> 8) & 255;
    endfunction

    function automatic int cube_ref(int k, int wx, int wy, int wz);
        int x3, x2, x1, x0, y1, y0;
        x3 = lerp_ref(hist[k],              hist[k-1],              wx);
        x2 = lerp_ref(hist[k-NX],           hist[k-NX-1],           wx);
        x1 = lerp_ref(hist[k-SLICE],        hist[k-SLICE-1],        wx);
        x0 = lerp_ref(hist[k-SLICE-NX],     hist[k-SLICE-NX-1],     wx);
        y1 = lerp_ref(x3, x2, wy);
        y0 = lerp_ref(x1, x0, wy);
        return lerp_ref(y1, y0, wz);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, t);
        end
    endtask

    // one cycle: compare outputs due now, then model and drive the next input
    task automatic step(bit v, bit s, int vox, int wx, int wy, int wz, int c, string tag);
        int old_slot;
        int idx;
        bit nv;
        @(negedge clk);
        old_slot = (t + 1) % 4;
        check(out_valid == ev[old_slot], et[old_slot], "valid", int'(out_valid), int'(ev[old_slot]));
        if (ev[old_slot] && out_valid) begin
            check(int'(out_sample) == es[old_slot], et[old_slot], "sample",
                  int'(out_sample), es[old_slot]);
            check(int'(out_ctrl) == ec[old_slot], "R9", "ctrl",
                  int'(out_ctrl), ec[old_slot]);
        end
        nv = 0;
        es[t % 4] = 0;
        if (v) begin
            idx = s ? 0 : cnt_m;
            hist[idx] = vox & 255;
            cnt_m = idx + 1;
            if (idx >= FILL) begin
                nv = 1;
                es[t % 4] = cube_ref(idx, wx & 255, wy & 255, wz & 255);
            end
        end
        ev[t % 4] = nv;
        ec[t % 4] = c & ((1 << CTRL_W) - 1);
        et[t % 4] = tag;
        in_valid = v;
        in_sov   = s;
        in_voxel = 8'(vox);
        in_wx    = 8'(wx);
        in_wy    = 8'(wy);
        in_wz    = 8'(wz);
        in_ctrl  = CTRL_W'(c);
        t++;
    endtask

    task automatic rnd_step(bit v, bit s, string tag);
        step(v, s, int'($urandom_range(255)), int'($urandom_range(255)),
             int'($urandom_range(255)), int'($urandom_range(255)),
             int'($urandom_range((1 << CTRL_W) - 1)), tag);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 4; i++) begin
            ev[i] = 0; es[i] = 0; ec[i] = 0; et[i] = "R1 reset";
        end
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid during reset", int'(out_valid), 0);
        rst_n = 1'b1;

        // R1: quiet after reset
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 0, "R1 idle");

        // R6: fill window on a constant volume, samples must equal the constant
        for (int i = 0; i < 120; i++)
            step(1, i == 0, 100, int'($urandom_range(255)), int'($urandom_range(255)),
                 int'($urandom_range(255)), i, "R6 fill");

        // R4: zero weights return the oldest corner; X-only weight checks tree order
        for (int i = 0; i < 150; i++)
            step(1, i == 0, int'($urandom_range(255)), (i % 2 == 0) ? 0 : 128, 0, 0, i,
                 "R4 weight order");

        // R2: maximum weights stress truncation
        for (int i = 0; i < 150; i++)
            step(1, i == 0, int'($urandom_range(255)), 255, 255, 255, i, "R2 weight max");

        // R8: random idle cycles inside a stream
        for (int i = 0; i < 400; i++)
            rnd_step((i == 0) || ($urandom_range(3) != 0), i == 0, "R8 stalls");

        // R7: start-of-volume in the middle of a running stream
        for (int i = 0; i < 260; i++)
            rnd_step(1, (i == 0) || (i == 120), "R7 restart");

        // R3 and R5: long unbroken random stream
        for (int i = 0; i < 400; i++)
            rnd_step(1, i == 0, "R3 R5 stream");

        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 0, "R5 drain");

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule